// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog timer peripheral that sits on a simple synchronous 16-bit register bus. A prescaler divides the system clock down to a fixed count tick, which is nominally 0.6 s. On each tick a 10-bit down-counter steps down by one. Software keeps the watchdog alive by writing the reload register, which copies the programmed start value back into the counter. Software can also halt the countdown, program the start value and read back the time that remains.

Expiry is handled in two stages. When the counter runs out the first time, the block sets a first-stage flag, can raise an interrupt, and starts a fresh countdown. If the counter runs out again while that flag is still set, the block sets a second-stage flag and requests a system reset. A no-reboot configuration bit can hold back that request. Every status flag is cleared by writing one to it. The block produces only the reset request level; the actual reset generation is left to the surrounding system.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset the values are as follows. The halt bit (bit 11 of offset 0x08) reads 1. The no-reboot bit (bit 5 of offset 0x20) reads 1. The interrupt enable (bit 13 of offset 0x30) reads 0. Every status flag reads 0. The start value at offset 0x12 and the count at offset 0x00 both equal INIT_DEFAULT (16). Both the interrupt and the reset request are low.
- R2: Writing any data to offset 0x00 loads the counter from the start-value register. Reading offset 0x00 returns the current count in bits 9:0, with the upper bits read as 0.
- R3: The start value lives in bits 9:0 of offset 0x12, and its bits 15:10 read as 0. A write whose bits 9:0 hold a value from 0 to 3 is dropped, and the earlier value stays in place.
- R4: The halt bit reads back as written. While it is 1 the count holds, and this includes the value loaded by a reload.
- R5: While the counter runs it steps down once every PRESCALE clocks. Take N as the value loaded by a reload or held when counting resumes. The first expiry then comes (N+1)·PRESCALE clocks after the write that started counting. That expiry sets the first-stage flag (bit 3 of offset 0x04) and reloads the counter.
- R6: The interrupt output is high exactly while the first-stage flag and the interrupt enable are both set. Clearing the enable leaves the flag itself unchanged.
- R7: An expiry while the first-stage flag is set sets the second-stage flag (bit 1 of offset 0x06). That flag stays set until software clears it. The reset request is high while the second-stage flag is set and the no-reboot bit is 0.
- R8: The no-reboot bit masks the reset request whenever it is 1. A second-stage expiry that happens while it is 1 also sets the boot flag (bit 2 of offset 0x06).
- R9: Each status flag is cleared by writing 1 to its bit position. Writing 0 to a status bit has no effect.
- R10: If the first-stage flag is cleared between two expiries, the next expiry counts as a first stage again. The second-stage flag is not set, and no reset request is made.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bus_sel_i | input | 1 | Bus access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 for a write, 0 for a read |
| bus_addr_i | input | ADDR_W (8) | Byte offset of the register |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, registered, valid the cycle after a read strobe |
| irq_o | output | 1 | First-stage interrupt request |
| sys_rst_req_o | output | 1 | Second-stage system reset request |

## Verification
The countdown is run over several service patterns. In the first, nothing is serviced, which must give an interrupt and then a reset request at exactly computed clocks. In the second, the first-stage flag is cleared between expiries, which must give a second first-stage expiry and no reset. In the third, the no-reboot bit is set before the second expiry, which separates the masked reset from the boot flag. Register accesses are mixed in to compare a legal start value with an illegal one, a write-one against a write-zero on each flag, and a reload with the counter halted against one with it running. A count read taken mid-run confirms the tick spacing.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   localparam int unsigned BUS_W    = 16;
   localparam int unsigned MIN_INIT = 4;

   // register offsets
   localparam logic [7:0] OFF_RELOAD = 8'h00;
   localparam logic [7:0] OFF_STS_A  = 8'h04;
   localparam logic [7:0] OFF_STS_B  = 8'h06;
   localparam logic [7:0] OFF_CTRL   = 8'h08;
   localparam logic [7:0] OFF_INIT   = 8'h12;
   localparam logic [7:0] OFF_CFG    = 8'h20;
   localparam logic [7:0] OFF_IEN    = 8'h30;

   // field positions
   localparam int unsigned BIT_HALT     = 11;
   localparam int unsigned BIT_FIRST    = 3;
   localparam int unsigned BIT_SECOND   = 1;
   localparam int unsigned BIT_BOOT     = 2;
   localparam int unsigned BIT_NOREBOOT = 5;
   localparam int unsigned BIT_IEN      = 13;

   typedef struct packed {
      logic reload;
      logic sts_a;
      logic sts_b;
      logic ctrl;
      logic init;
      logic cfg;
      logic ien;
   } wdt_hit_t;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
   parameter int unsigned DIV = 75_000_000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   input  logic restart_i,
   output logic tick_o
);
   localparam int unsigned PW   = (DIV > 2) ? $clog2(DIV) : 1;
   localparam logic [PW-1:0] LAST = PW'(DIV - 1);

   logic [PW-1:0] pcnt;

   generate
      if ((DIV & (DIV - 1)) == 0) begin : g_pow2
         // natural wrap, no compare on the wrap path
         always_ff @(posedge clk_i) begin
            if (!rst_ni || restart_i || !run_i) pcnt <= '0;
            else                                pcnt <= pcnt + 1'b1;
         end
         assign tick_o = run_i && !restart_i && (&pcnt);
      end else begin : g_modulo
         always_ff @(posedge clk_i) begin
            if (!rst_ni || restart_i || !run_i) pcnt <= '0;
            else if (pcnt == LAST)              pcnt <= '0;
            else                                pcnt <= pcnt + 1'b1;
         end
         assign tick_o = run_i && !restart_i && (pcnt == LAST);
      end
   endgenerate
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
   parameter int unsigned CNT_W    = 10,
   parameter int unsigned INIT_RST = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             tick_i,
   output logic [CNT_W-1:0] count_o,
   output logic             expire_o
);
   logic at_zero;
   assign at_zero  = (count_o == '0);
   assign expire_o = tick_i && !load_i && at_zero;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)         count_o <= CNT_W'(INIT_RST);
      else if (load_i)     count_o <= load_val_i;
      else if (tick_i) begin
         if (at_zero)      count_o <= load_val_i;
         else              count_o <= count_o - 1'b1;
      end
   end
endmodule

// File: rtl/wdt_stage_flags.sv
module wdt_stage_flags (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic expire_i,
   input  logic clr_first_i,
   input  logic clr_second_i,
   input  logic clr_boot_i,
   input  logic no_reboot_i,
   input  logic irq_en_i,
   output logic first_o,
   output logic second_o,
   output logic boot_o,
   output logic irq_o,
   output logic rst_req_o
);
   logic escalate;
   assign escalate = expire_i && first_o;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         first_o  <= 1'b0;
         second_o <= 1'b0;
         boot_o   <= 1'b0;
      end else begin
         if (expire_i)          first_o  <= 1'b1;
         else if (clr_first_i)  first_o  <= 1'b0;

         if (escalate)          second_o <= 1'b1;
         else if (clr_second_i) second_o <= 1'b0;

         if (escalate && no_reboot_i) boot_o <= 1'b1;
         else if (clr_boot_i)         boot_o <= 1'b0;
      end
   end

   assign irq_o     = first_o && irq_en_i;
   assign rst_req_o = second_o && !no_reboot_i;
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
   import wdt_pkg::*;
#(
   parameter int unsigned ADDR_W       = 8,
   parameter int unsigned CNT_W        = 10,
   parameter int unsigned PRESCALE     = 75_000_000,
   parameter int unsigned INIT_DEFAULT = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              bus_sel_i,
   input  logic              bus_we_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [15:0]       bus_wdata_i,
   output logic [15:0]       bus_rdata_o,
   output logic              irq_o,
   output logic              sys_rst_req_o
);
   generate
      if (PRESCALE < 2) begin : g_bad_div
         $error("PRESCALE must be at least 2");
      end
      if (CNT_W < 3 || CNT_W > BUS_W) begin : g_bad_w
         $error("CNT_W out of range");
      end
      if (INIT_DEFAULT < MIN_INIT || INIT_DEFAULT >= (1 << CNT_W)) begin : g_bad_init
         $error("INIT_DEFAULT must be legal");
      end
      if (ADDR_W < 6) begin : g_bad_addr
         $error("ADDR_W too narrow for the register offsets");
      end
   endgenerate

   // bus decode
   logic     wr, rd;
   wdt_hit_t hit;
   assign wr = bus_sel_i && bus_we_i;
   assign rd = bus_sel_i && !bus_we_i;

   always_comb begin
      hit        = '0;
      hit.reload = (bus_addr_i == ADDR_W'(OFF_RELOAD));
      hit.sts_a  = (bus_addr_i == ADDR_W'(OFF_STS_A));
      hit.sts_b  = (bus_addr_i == ADDR_W'(OFF_STS_B));
      hit.ctrl   = (bus_addr_i == ADDR_W'(OFF_CTRL));
      hit.init   = (bus_addr_i == ADDR_W'(OFF_INIT));
      hit.cfg    = (bus_addr_i == ADDR_W'(OFF_CFG));
      hit.ien    = (bus_addr_i == ADDR_W'(OFF_IEN));
   end

   // software-visible control state
   logic             halt_q, no_reboot_q, ien_q;
   logic [CNT_W-1:0] init_q;
   logic [CNT_W-1:0] init_wr;
   logic             init_legal;

   assign init_wr    = bus_wdata_i[CNT_W-1:0];
   assign init_legal = (init_wr >= CNT_W'(MIN_INIT));

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         halt_q      <= 1'b1;
         no_reboot_q <= 1'b1;
         ien_q       <= 1'b0;
         init_q      <= CNT_W'(INIT_DEFAULT);
      end else if (wr) begin
         if (hit.ctrl)               halt_q      <= bus_wdata_i[BIT_HALT];
         if (hit.cfg)                no_reboot_q <= bus_wdata_i[BIT_NOREBOOT];
         if (hit.ien)                ien_q       <= bus_wdata_i[BIT_IEN];
         if (hit.init && init_legal) init_q      <= init_wr;
      end
   end

   logic unused_wdata;
   assign unused_wdata = ^{bus_wdata_i[15:14], bus_wdata_i[12], bus_wdata_i[10],
                           bus_wdata_i[4], bus_wdata_i[0]};

   // datapath
   logic             reload_wr, tick, expire;
   logic [CNT_W-1:0] count;
   logic             sts_first, sts_second, sts_boot;
   logic             clr_first, clr_second, clr_boot;

   assign reload_wr  = wr && hit.reload;
   assign clr_first  = wr && hit.sts_a && bus_wdata_i[BIT_FIRST];
   assign clr_second = wr && hit.sts_b && bus_wdata_i[BIT_SECOND];
   assign clr_boot   = wr && hit.sts_b && bus_wdata_i[BIT_BOOT];

   wdt_prescaler #(.DIV(PRESCALE)) u_presc (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (!halt_q),
      .restart_i (reload_wr),
      .tick_o    (tick)
   );

   wdt_countdown #(.CNT_W(CNT_W), .INIT_RST(INIT_DEFAULT)) u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (reload_wr),
      .load_val_i (init_q),
      .tick_i     (tick),
      .count_o    (count),
      .expire_o   (expire)
   );

   wdt_stage_flags u_flags (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .expire_i     (expire),
      .clr_first_i  (clr_first),
      .clr_second_i (clr_second),
      .clr_boot_i   (clr_boot),
      .no_reboot_i  (no_reboot_q),
      .irq_en_i     (ien_q),
      .first_o      (sts_first),
      .second_o     (sts_second),
      .boot_o       (sts_boot),
      .irq_o        (irq_o),
      .rst_req_o    (sys_rst_req_o)
   );

   // read path
   logic [15:0] rd_mux;
   always_comb begin
      rd_mux = '0;
      unique case (1'b1)
         hit.reload: rd_mux[CNT_W-1:0]    = count;
         hit.init:   rd_mux[CNT_W-1:0]    = init_q;
         hit.ctrl:   rd_mux[BIT_HALT]     = halt_q;
         hit.sts_a:  rd_mux[BIT_FIRST]    = sts_first;
         hit.sts_b: begin
                     rd_mux[BIT_SECOND]   = sts_second;
                     rd_mux[BIT_BOOT]     = sts_boot;
         end
         hit.cfg:    rd_mux[BIT_NOREBOOT] = no_reboot_q;
         hit.ien:    rd_mux[BIT_IEN]      = ien_q;
         default:    rd_mux               = '0;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni)  bus_rdata_o <= '0;
      else if (rd)  bus_rdata_o <= rd_mux;
   end
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
   parameter int unsigned CNT_W = 10
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             halt,
   input logic             load,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] init_val,
   input logic             sts_second,
   input logic             clr_second,
   input logic             no_reboot,
   input logic             irq_en,
   input logic             irq,
   input logic             rst_req
);
   a_r4_halt_freezes: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (halt && !load) |=> $stable(count));

   a_r2_reload_copies: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load |=> (count == $past(init_val)));

   a_r3_init_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
      init_val >= CNT_W'(4));

   a_r6_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq |-> irq_en);

   a_r8_noreboot_masks: assert property (@(posedge clk_i) disable iff (!rst_ni)
      no_reboot |-> !rst_req);

   a_r7_second_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sts_second && !clr_second) |=> sts_second);
endmodule

bind wdog_two_stage wdt_checker #(.CNT_W(CNT_W)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .halt       (halt_q),
   .load       (reload_wr),
   .count      (count),
   .init_val   (init_q),
   .sts_second (sts_second),
   .clr_second (clr_second),
   .no_reboot  (no_reboot_q),
   .irq_en     (ien_q),
   .irq        (irq_o),
   .rst_req    (sys_rst_req_o)
);

// File: tb/wdog_two_stage_bench.sv
module wdog_two_stage_bench;
   localparam int unsigned PRE = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel = 1'b0, we = 1'b0;
   logic [7:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        irq, sreq;

   always #4 clk = ~clk;

   wdog_two_stage #(.PRESCALE(PRE), .INIT_DEFAULT(16)) u_wdog_two_stage (
      .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we),
      .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
      .irq_o(irq), .sys_rst_req_o(sreq)
   );

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;
   int last_edge = 0;
   logic rd_q = 1'b0;

   logic [15:0] exp_q[$];
   string       tag_q[$];

   always @(posedge clk) begin
      cyc  <= cyc + 1;
      rd_q <= sel && !we;
   end

   // scoreboard monitor: compares each read response with the queued expectation
   always @(negedge clk) begin
      if (rd_q) begin
         n_tests++;
         if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL unexpected read response: actual %h expected none", rdata);
         end else begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (rdata !== e) begin
               n_fail++;
               $display("FAIL %s: actual %h expected %h", t, rdata, e);
            end
         end
      end
   end

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   task automatic bus_wr(input logic [7:0] a, input logic [15:0] d);
      @(negedge clk);
      sel = 1'b1; we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      sel = 1'b0; we = 1'b0;
      last_edge = cyc;
   endtask

   task automatic bus_rd(input logic [7:0] a, input logic [15:0] e, input string t);
      @(negedge clk);
      exp_q.push_back(e);
      tag_q.push_back(t);
      sel = 1'b1; we = 1'b0; addr = a;
      @(negedge clk);
      sel = 1'b0;
   endtask

   task automatic chk(input logic act, input logic e, input string t);
      n_tests++;
      if (act !== e) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b", t, act, e);
      end
   endtask

   task automatic wait_until(input int t);
      while (cyc < t) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
      $finish;
   end

   initial begin
      int e0, e1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk(irq, 1'b0, "R1 irq after reset");
      chk(sreq, 1'b0, "R1 reset request after reset");
      bus_rd(8'h08, 16'h0800, "R1 halt bit set");
      bus_rd(8'h20, 16'h0020, "R1 no-reboot set");
      bus_rd(8'h30, 16'h0000, "R1 irq enable clear");
      bus_rd(8'h04, 16'h0000, "R1 first flag clear");
      bus_rd(8'h06, 16'h0000, "R1 second/boot clear");
      bus_rd(8'h12, 16'h0010, "R1 default start value");
      bus_rd(8'h00, 16'h0010, "R1 default count");

      // R3 start value: illegal ignored, upper bits read zero
      bus_wr(8'h12, 16'h0002);
      bus_rd(8'h12, 16'h0010, "R3 value 2 ignored");
      bus_wr(8'h12, 16'h0003);
      bus_rd(8'h12, 16'h0010, "R3 value 3 ignored");
      bus_wr(8'h12, 16'hFC05);
      bus_rd(8'h12, 16'h0005, "R3 legal value, upper bits zero");

      // R2 / R4 reload while halted
      bus_wr(8'h00, 16'hABCD);
      bus_rd(8'h00, 16'h0005, "R2 reload loads start value");
      repeat (20) @(negedge clk);
      bus_rd(8'h00, 16'h0005, "R4 halted count holds");

      // R5/R6/R7 unserviced run
      bus_wr(8'h30, 16'h2000);
      bus_rd(8'h30, 16'h2000, "R6 irq enable reads back");
      bus_wr(8'h20, 16'h0000);
      bus_wr(8'h08, 16'h0000);
      e0 = last_edge;
      bus_rd(8'h08, 16'h0000, "R4 halt reads back 0");
      wait_until(e0 + 9);
      bus_rd(8'h00, 16'h0003, "R5 count mid-run");
      wait_until(e0 + 23);
      chk(irq, 1'b0, "R5 no expiry before (N+1)*PRESCALE");
      wait_until(e0 + 24);
      chk(irq, 1'b1, "R5/R6 first expiry raises irq");
      chk(sreq, 1'b0, "R7 no reset at first expiry");
      bus_rd(8'h04, 16'h0008, "R5 first flag set");
      wait_until(e0 + 47);
      chk(sreq, 1'b0, "R7 no reset before second expiry");
      wait_until(e0 + 48);
      chk(sreq, 1'b1, "R7 second expiry requests reset");
      bus_rd(8'h06, 16'h0002, "R7 second flag set, boot clear");
      bus_wr(8'h08, 16'h0800);

      // R8 gate, R7 sticky, R9 write-one-to-clear
      bus_wr(8'h20, 16'h0020);
      chk(sreq, 1'b0, "R8 no-reboot masks reset");
      bus_wr(8'h20, 16'h0000);
      chk(sreq, 1'b1, "R7 second flag sticky");
      bus_wr(8'h06, 16'h0000);
      chk(sreq, 1'b1, "R9 write zero keeps second flag");
      bus_wr(8'h06, 16'h0002);
      chk(sreq, 1'b0, "R9 write one clears second flag");
      bus_wr(8'h04, 16'h0000);
      chk(irq, 1'b1, "R9 write zero keeps first flag");
      bus_wr(8'h30, 16'h0000);
      chk(irq, 1'b0, "R6 irq disabled");
      bus_rd(8'h04, 16'h0008, "R6 flag kept while irq disabled");
      bus_wr(8'h30, 16'h2000);
      chk(irq, 1'b1, "R6 irq re-enabled");
      bus_wr(8'h04, 16'h0008);
      chk(irq, 1'b0, "R9 write one clears first flag");

      // R10 serviced between expiries, then R8 boot flag
      bus_wr(8'h00, 16'h0000);
      bus_wr(8'h08, 16'h0000);
      e1 = last_edge;
      wait_until(e1 + 24);
      chk(irq, 1'b1, "R10 first expiry");
      bus_wr(8'h04, 16'h0008);
      chk(irq, 1'b0, "R10 flag cleared");
      wait_until(e1 + 47);
      chk(irq, 1'b0, "R10 no expiry yet");
      wait_until(e1 + 48);
      chk(irq, 1'b1, "R10 next expiry is first stage");
      chk(sreq, 1'b0, "R10 no reset after service");
      bus_rd(8'h06, 16'h0000, "R10 second flag not set");
      bus_wr(8'h20, 16'h0020);
      wait_until(e1 + 72);
      chk(sreq, 1'b0, "R8 masked second expiry");
      bus_rd(8'h06, 16'h0006, "R8 boot and second flags set");
      bus_wr(8'h08, 16'h0800);
      bus_wr(8'h06, 16'h0006);
      bus_rd(8'h06, 16'h0000, "R9 both flags cleared");

      repeat (2) @(negedge clk);
      if (exp_q.size() != 0) begin
         n_fail++;
         $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
      end
      summary();
      $finish;
   end
endmodule